// File: doc/BRIEF.md
# Configurable Set-Associative Byte Cache

This block is a parameterised cache controller. It sits between a processor-side byte request port and a backing memory that moves whole blocks. Storage is organised as 2^SETS_LOG2 sets. Each set holds 2^WAYS_LOG2 lines, and each line holds a 2^OFF_LOG2-byte block together with a valid bit and a tag. With one way the cache is direct mapped. With one set it is fully associative. Every way of the selected set is compared in parallel, so a hit is answered in the cycle after the request is taken.

On a miss the controller fetches the whole block in one memory transaction. It refills an empty way when the set has one. Otherwise it replaces the least recently used way, tracked by an age counter per way. The compile-time parameter WRITE_BACK selects the write policy:
- When it is 1, writes stay in the cache and mark the line dirty. A dirty line is copied out when it is evicted, and a write miss first brings the block in.
- When it is 0, every write goes to memory at once. A write hit also updates the cached copy, while a write miss leaves the cache untouched.

Top module: `assoc_cache`

## Requirements
- R1: An address splits into tag (upper ADDR_W-SETS_LOG2-OFF_LOG2 bits), set index (next SETS_LOG2 bits) and byte offset (lowest OFF_LOG2 bits). Every memory transaction carries the block address, which is the byte address shifted right by OFF_LOG2.
- R2: A read hits when some way of the indexed set is valid and holds the request tag. Then rsp_valid pulses for one cycle in the cycle after acceptance, with the byte selected by the offset. No memory transaction is started, and req_ready stays high.
- R3: Reset clears all valid bits, dirty bits and age state. After reset, req_ready is 1, rsp_valid and mem_req are 0, and the first access to any address misses.
- R4: A read miss issues exactly one block fill (mem_we=0). After mem_ack the line is valid with the new tag, and rsp_valid returns the requested byte of the fetched block.
- R5: On a miss, the lowest-numbered invalid way of the set is refilled before any valid line is displaced.
- R6: When all ways of a set are valid, the way accessed least recently, by hit or fill, is replaced.
- R7: With WRITE_BACK=1, a write hit changes only the cached byte and marks the line dirty. Memory is not written, and a later read returns the new byte.
- R8: With WRITE_BACK=1, a dirty victim is first written to memory as a full block: all mem_wstrb bits set, at the victim's own block address. The fill follows. A clean victim is replaced without a write.
- R9: With WRITE_BACK=1, a write miss fills the block, merges the written byte, leaves memory unchanged and makes the line valid and dirty.
- R10: With WRITE_BACK=0, a write hit updates the cached byte and also issues one memory write whose only set strobe bit is the one at the offset lane. The byte appears on every lane of mem_wdata.
- R11: With WRITE_BACK=0, a write miss issues only a single-byte memory write and allocates nothing, so a later read of that address misses and returns the written byte.
- R12: req_ready is low whenever mem_req is high. mem_req, mem_addr, mem_we and mem_wstrb stay stable from the start of a memory transaction until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request taken at this edge when high with req_valid |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 8 | Read byte |
| mem_req | output | 1 | Memory transaction active, held until mem_ack |
| mem_we | output | 1 | 1 = write to memory, 0 = block fill |
| mem_addr | output | ADDR_W-OFF_LOG2 | Block address |
| mem_wdata | output | 8*2^OFF_LOG2 | Block write data |
| mem_wstrb | output | 2^OFF_LOG2 | Byte lane enables for writes |
| mem_rdata | input | 8*2^OFF_LOG2 | Fill data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current transaction |

## Verification
The two functions that can meet in one memory episode are the write-back of a dirty victim and the fill of the missing block. Both come from one read request and run back to back while req_ready stays low. The bench provokes this by dirtying a line with a write hit and then touching two new tags in the same set, so that the dirty line becomes least recently used and is evicted. It judges the result at the ports: one write at the old block address carrying the dirtied byte, then one fill, and a response byte that belongs to the new block. Random mixed traffic over eight tags per set repeats the collision many times, and every read is compared with a byte-level reference image.

// File: rtl/cache_pkg.sv
package cache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2,
      ST_WTHRU = 2'd3
   } cache_state_e;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
   parameter int WAYS  = 2,
   parameter int WAY_W = 1,
   parameter int TAG_W = 6
) (
   input  logic [WAYS-1:0]            line_valid,
   input  logic [WAYS-1:0][TAG_W-1:0] line_tags,
   input  logic [TAG_W-1:0]           look_tag,
   input  logic [WAY_W-1:0]           lru_way,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way,
   output logic [WAY_W-1:0]           victim_way
);
   // parallel compare across all ways; empty ways win over the age choice
   always_comb begin
      hit        = 1'b0;
      hit_way    = '0;
      victim_way = lru_way;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!line_valid[w]) victim_way = WAY_W'(w);
      end
      for (int w = 0; w < WAYS; w++) begin
         if (line_valid[w] && line_tags[w] == look_tag) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
   end
endmodule

// File: rtl/cache_age_lru.sv
module cache_age_lru #(
   parameter int SETS  = 4,
   parameter int WAYS  = 2,
   parameter int SET_W = 2,
   parameter int WAY_W = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [SET_W-1:0] query_set,
   output logic [WAY_W-1:0] lru_way
);
   generate
      if (WAYS == 1) begin : g_single
         assign lru_way = '0;
      end else begin : g_ages
         logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int s = 0; s < SETS; s++)
                  for (int w = 0; w < WAYS; w++)
                     age_q[s][w] <= WAY_W'(w);
            end else if (touch_en) begin
               for (int w = 0; w < WAYS; w++) begin
                  if (WAY_W'(w) == touch_way)
                     age_q[touch_set][w] <= '0;
                  else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                     age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
               end
            end
         end

         always_comb begin
            lru_way = '0;
            for (int w = 0; w < WAYS; w++)
               if (age_q[query_set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
         end
      end
   endgenerate
endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
   import cache_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int SETS_LOG2  = 2,
   parameter int WAYS_LOG2  = 1,
   parameter int OFF_LOG2   = 2,
   parameter bit WRITE_BACK = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              req_valid,
   input  logic                              req_write,
   input  logic [ADDR_W-1:0]                 req_addr,
   input  logic [7:0]                        req_wdata,
   output logic                              req_ready,
   output logic                              rsp_valid,
   output logic [7:0]                        rsp_rdata,
   output logic                              mem_req,
   output logic                              mem_we,
   output logic [ADDR_W-OFF_LOG2-1:0]        mem_addr,
   output logic [8*(1<<OFF_LOG2)-1:0]        mem_wdata,
   output logic [(1<<OFF_LOG2)-1:0]          mem_wstrb,
   input  logic [8*(1<<OFF_LOG2)-1:0]        mem_rdata,
   input  logic                              mem_ack
);
   localparam int SETS      = 1 << SETS_LOG2;
   localparam int WAYS      = 1 << WAYS_LOG2;
   localparam int BLK_BYTES = 1 << OFF_LOG2;
   localparam int LINE_W    = 8 * BLK_BYTES;
   localparam int TAG_W     = ADDR_W - SETS_LOG2 - OFF_LOG2;
   localparam int SET_W     = (SETS_LOG2 > 0) ? SETS_LOG2 : 1;
   localparam int WAY_W     = (WAYS_LOG2 > 0) ? WAYS_LOG2 : 1;
   localparam int BADDR_W   = ADDR_W - OFF_LOG2;

   if (TAG_W < 1) begin : g_bad_tag
      $error("assoc_cache: address too narrow for set and offset fields");
   end
   if (OFF_LOG2 < 1) begin : g_bad_off
      $error("assoc_cache: block must hold at least two bytes");
   end

   cache_state_e state_q;
   logic [ADDR_W-1:0] q_addr;
   logic              q_write;
   logic [7:0]        q_wdata;
   logic [WAY_W-1:0]  q_way;

   logic [WAYS-1:0]                valid_q [SETS];
   logic [WAYS-1:0]                dirty_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0]     tag_q   [SETS];
   logic [WAYS-1:0][LINE_W-1:0]    data_q  [SETS];

   logic [TAG_W-1:0]    in_tag, q_tag;
   logic [OFF_LOG2-1:0] in_off, q_off;
   logic [SET_W-1:0]    in_set, q_set;
   logic [BADDR_W-1:0]  wb_baddr;

   assign in_tag = req_addr[ADDR_W-1 -: TAG_W];
   assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
   assign in_off = req_addr[OFF_LOG2-1:0];
   assign q_off  = q_addr[OFF_LOG2-1:0];

   generate
      if (SETS_LOG2 == 0) begin : g_one_set
         assign in_set   = '0;
         assign q_set    = '0;
         assign wb_baddr = tag_q[q_set][q_way];
      end else begin : g_many_sets
         assign in_set   = req_addr[OFF_LOG2 +: SETS_LOG2];
         assign q_set    = q_addr[OFF_LOG2 +: SETS_LOG2];
         assign wb_baddr = {tag_q[q_set][q_way], q_set};
      end
   endgenerate

   logic             lk_hit;
   logic [WAY_W-1:0] lk_hit_way, lk_victim, lru_way;
   logic [WAYS-1:0]  set_valid;
   assign set_valid = valid_q[in_set];

   cache_tag_match #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_match (
      .line_valid (set_valid),
      .line_tags  (tag_q[in_set]),
      .look_tag   (in_tag),
      .lru_way    (lru_way),
      .hit        (lk_hit),
      .hit_way    (lk_hit_way),
      .victim_way (lk_victim)
   );

   logic             fill_done, touch_en;
   logic [SET_W-1:0] touch_set;
   logic [WAY_W-1:0] touch_way;
   assign fill_done = (state_q == ST_FILL) && mem_ack;
   assign touch_en  = ((state_q == ST_IDLE) && req_valid && lk_hit) || fill_done;
   assign touch_set = fill_done ? q_set : in_set;
   assign touch_way = fill_done ? q_way : lk_hit_way;

   cache_age_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
      .clk       (clk),
      .rst       (rst),
      .touch_en  (touch_en),
      .touch_set (touch_set),
      .touch_way (touch_way),
      .query_set (in_set),
      .lru_way   (lru_way)
   );

   logic [LINE_W-1:0] fill_line;
   always_comb begin
      fill_line = mem_rdata;
      if (q_write) fill_line[8*q_off +: 8] = q_wdata;
   end

   assign req_ready = (state_q == ST_IDLE);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = q_addr[ADDR_W-1:OFF_LOG2];
      mem_wdata = '0;
      mem_wstrb = '0;
      case (state_q)
         ST_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = wb_baddr;
            mem_wdata = data_q[q_set][q_way];
            mem_wstrb = '1;
         end
         ST_FILL: mem_req = 1'b1;
         ST_WTHRU: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = {BLK_BYTES{q_wdata}};
            mem_wstrb = BLK_BYTES'(1) << q_off;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         q_addr    <= '0;
         q_write   <= 1'b0;
         q_wdata   <= '0;
         q_way     <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
         end
      end else begin
         rsp_valid <= 1'b0;
         case (state_q)
            ST_IDLE: if (req_valid) begin
               q_addr  <= req_addr;
               q_write <= req_write;
               q_wdata <= req_wdata;
               q_way   <= lk_victim;
               if (lk_hit) begin
                  if (!req_write) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= data_q[in_set][lk_hit_way][8*in_off +: 8];
                  end else begin
                     data_q[in_set][lk_hit_way][8*in_off +: 8] <= req_wdata;
                     if (WRITE_BACK) dirty_q[in_set][lk_hit_way] <= 1'b1;
                     else            state_q <= ST_WTHRU;
                  end
               end else if (req_write && !WRITE_BACK) begin
                  state_q <= ST_WTHRU;
               end else if (WRITE_BACK && valid_q[in_set][lk_victim] &&
                            dirty_q[in_set][lk_victim]) begin
                  state_q <= ST_WBACK;
               end else begin
                  state_q <= ST_FILL;
               end
            end
            ST_WBACK: if (mem_ack) state_q <= ST_FILL;
            ST_FILL: if (mem_ack) begin
               data_q[q_set][q_way]  <= fill_line;
               tag_q[q_set][q_way]   <= q_tag;
               valid_q[q_set][q_way] <= 1'b1;
               dirty_q[q_set][q_way] <= WRITE_BACK && q_write;
               if (!q_write) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= mem_rdata[8*q_off +: 8];
               end
               state_q <= ST_IDLE;
            end
            ST_WTHRU: if (mem_ack) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/assoc_cache_chk.sv
module assoc_cache_chk #(
   parameter int BADDR_W   = 10,
   parameter int BLK_BYTES = 4,
   parameter int WAYS      = 2,
   parameter int WAY_W     = 1
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 req_valid,
   input logic                 req_write,
   input logic                 req_ready,
   input logic                 rsp_valid,
   input logic                 mem_req,
   input logic                 mem_we,
   input logic [BADDR_W-1:0]   mem_addr,
   input logic [BLK_BYTES-1:0] mem_wstrb,
   input logic                 mem_ack,
   input logic                 lk_hit,
   input logic [WAY_W-1:0]     lk_hit_way,
   input logic [WAYS-1:0]      set_valid
);
   // R12: processor side is stalled while memory is busy
   p_stall_r12: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> !req_ready);

   // R12: a pending memory transaction holds its fields
   p_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wstrb)));

   // R2: a response follows an accepted read or a completed transaction
   p_rsp_src_r2: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> ($past(req_valid && req_ready && !req_write) || $past(mem_ack)));

   // R2: a reported hit always names a valid way
   p_hit_valid_r2: assert property (@(posedge clk) disable iff (rst)
      lk_hit |-> set_valid[lk_hit_way]);

   // R8: a finished full-block write-back is followed by the fill
   p_wb_fill_r8: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_we && mem_ack && (&mem_wstrb)) |=> (mem_req && !mem_we));

   // R10: memory writes are either a whole block or a single byte lane
   p_strobe_r10: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_we) |-> ((&mem_wstrb) || $countones(mem_wstrb) == 1));
endmodule

bind assoc_cache assoc_cache_chk #(
   .BADDR_W   (BADDR_W),
   .BLK_BYTES (BLK_BYTES),
   .WAYS      (WAYS),
   .WAY_W     (WAY_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wstrb  (mem_wstrb),
   .mem_ack    (mem_ack),
   .lk_hit     (lk_hit),
   .lk_hit_way (lk_hit_way),
   .set_valid  (set_valid)
);

// File: tb/sim_mem.sv
module sim_mem #(
   parameter int ADDR_W   = 10,
   parameter int OFF_LOG2 = 2
) (
   input  logic                            clk,
   input  logic                            mem_req,
   input  logic                            mem_we,
   input  logic [ADDR_W-OFF_LOG2-1:0]      mem_addr,
   input  logic [8*(1<<OFF_LOG2)-1:0]      mem_wdata,
   input  logic [(1<<OFF_LOG2)-1:0]        mem_wstrb,
   output logic [8*(1<<OFF_LOG2)-1:0]      mem_rdata,
   output logic                            mem_ack
);
   localparam int BLK = 1 << OFF_LOG2;
   logic [7:0] bytes [1<<ADDR_W];
   int n_fill = 0;
   int n_write = 0;
   int last_fill = -1;
   int last_wr = -1;
   bit init_done = 0;

   function automatic logic [7:0] seed_byte(int a);
      return 8'(a * 13 + 5);
   endfunction

   initial begin
      mem_ack   = 1'b0;
      mem_rdata = '0;
   end

   always @(negedge clk) begin
      if (!init_done) begin
         for (int i = 0; i < (1 << ADDR_W); i++) bytes[i] <= seed_byte(i);
         init_done <= 1;
         mem_ack <= 1'b0;
      end else if (mem_req && !mem_ack) begin
         if (mem_we) begin
            for (int b = 0; b < BLK; b++)
               if (mem_wstrb[b]) bytes[int'(mem_addr) * BLK + b] <= mem_wdata[8*b +: 8];
            n_write <= n_write + 1;
            last_wr <= int'(mem_addr);
         end else begin
            for (int b = 0; b < BLK; b++)
               mem_rdata[8*b +: 8] <= bytes[int'(mem_addr) * BLK + b];
            n_fill <= n_fill + 1;
            last_fill <= int'(mem_addr);
         end
         mem_ack <= 1'b1;
      end else begin
         mem_ack <= 1'b0;
      end
   end
endmodule

// File: tb/sim_assoc_cache.sv
`timescale 1ns/1ps
module sim_assoc_cache;
   localparam int AW = 10;
   localparam int OB = 2;
   localparam int BW = AW - OB;
   localparam int LW = 8 << OB;

   logic clk = 0;
   logic rst = 1;
   always #10 clk = ~clk;

   logic v0 = 0, w0 = 0, v1 = 0, w1 = 0;
   logic [AW-1:0] a0 = '0, a1 = '0;
   logic [7:0] d0 = '0, d1 = '0;
   logic rdy0, rv0, rdy1, rv1;
   logic [7:0] rd0, rd1;
   logic mreq0, mwe0, mack0, mreq1, mwe1, mack1;
   logic [BW-1:0] maddr0, maddr1;
   logic [LW-1:0] mwd0, mrd0, mwd1, mrd1;
   logic [(1<<OB)-1:0] mst0, mst1;

   assoc_cache #(.ADDR_W(AW), .SETS_LOG2(2), .WAYS_LOG2(1), .OFF_LOG2(OB), .WRITE_BACK(1'b1)) u0 (
      .clk(clk), .rst(rst), .req_valid(v0), .req_write(w0), .req_addr(a0), .req_wdata(d0),
      .req_ready(rdy0), .rsp_valid(rv0), .rsp_rdata(rd0), .mem_req(mreq0), .mem_we(mwe0),
      .mem_addr(maddr0), .mem_wdata(mwd0), .mem_wstrb(mst0), .mem_rdata(mrd0), .mem_ack(mack0));
   sim_mem #(.ADDR_W(AW), .OFF_LOG2(OB)) m0 (
      .clk(clk), .mem_req(mreq0), .mem_we(mwe0), .mem_addr(maddr0), .mem_wdata(mwd0),
      .mem_wstrb(mst0), .mem_rdata(mrd0), .mem_ack(mack0));

   assoc_cache #(.ADDR_W(AW), .SETS_LOG2(2), .WAYS_LOG2(1), .OFF_LOG2(OB), .WRITE_BACK(1'b0)) u1 (
      .clk(clk), .rst(rst), .req_valid(v1), .req_write(w1), .req_addr(a1), .req_wdata(d1),
      .req_ready(rdy1), .rsp_valid(rv1), .rsp_rdata(rd1), .mem_req(mreq1), .mem_we(mwe1),
      .mem_addr(maddr1), .mem_wdata(mwd1), .mem_wstrb(mst1), .mem_rdata(mrd1), .mem_ack(mack1));
   sim_mem #(.ADDR_W(AW), .OFF_LOG2(OB)) m1 (
      .clk(clk), .mem_req(mreq1), .mem_we(mwe1), .mem_addr(maddr1), .mem_wdata(mwd1),
      .mem_wstrb(mst1), .mem_rdata(mrd1), .mem_ack(mack1));

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] gold [1<<AW];

   function automatic logic [7:0] seed_byte(int a);
      return 8'(a * 13 + 5);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic access(input int w, input bit wr, input int a, input logic [7:0] d,
                         output logic [7:0] rd, output int lat, output bit stalled);
      bit got;
      int guard;
      @(negedge clk);
      if (w == 0) begin v0 = 1; w0 = wr; a0 = AW'(a); d0 = d; end
      else        begin v1 = 1; w1 = wr; a1 = AW'(a); d1 = d; end
      guard = 0;
      while (((w == 0) ? rdy0 : rdy1) == 1'b0 && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      v0 = 0; v1 = 0;
      lat = 1;
      stalled = ((w == 0) ? rdy0 : rdy1) == 1'b0;
      got = 0;
      rd = '0;
      forever begin
         if ((w == 0) ? rv0 : rv1) begin
            rd = (w == 0) ? rd0 : rd1;
            got = 1;
         end
         if (((w == 0) ? rdy0 : rdy1) && (wr || got)) break;
         if (lat > 300) break;
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      int lat, f, wc, rnd;
      bit st;
      for (int i = 0; i < (1 << AW); i++) gold[i] = seed_byte(i);
      repeat (4) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R3: reset state
      chk(rdy0 == 1 && rv0 == 0 && mreq0 == 0, "R3 reset outputs", {rdy0, rv0, mreq0}, 3'b100);

      // R3 / R4 / R1: first read misses and fetches the block address
      f = m0.n_fill;
      access(0, 0, 'h010, 0, rd, lat, st);
      chk(m0.n_fill == f + 1, "R3 first access misses", m0.n_fill - f, 1);
      chk(rd == gold['h010], "R4 miss data", rd, gold['h010]);
      chk(m0.last_fill == 'h004, "R1 fill block address", m0.last_fill, 'h004);
      chk(st == 1, "R12 ready low during fill", st, 1);
      access(0, 0, 'h3B7, 0, rd, lat, st);
      chk(m0.last_fill == 'h0ED && rd == gold['h3B7], "R1 split high tag", m0.last_fill, 'h0ED);

      // R2: hit on the same block
      f = m0.n_fill;
      access(0, 0, 'h013, 0, rd, lat, st);
      chk(rd == gold['h013], "R2 hit data", rd, gold['h013]);
      chk(lat == 1 && st == 0 && m0.n_fill == f, "R2 hit latency", lat, 1);

      // R5: second tag fills the empty way, first tag survives
      access(0, 0, 'h020, 0, rd, lat, st);
      chk(m0.n_fill == f + 1, "R5 fill into empty way", m0.n_fill - f, 1);
      access(0, 0, 'h011, 0, rd, lat, st);
      chk(lat == 1 && rd == gold['h011], "R5 first way kept", lat, 1);
      access(0, 0, 'h021, 0, rd, lat, st);
      chk(lat == 1 && m0.n_fill == f + 1, "R5 second way hit", lat, 1);

      // R6: least recently used tag (0x01x) is displaced
      access(0, 0, 'h030, 0, rd, lat, st);
      chk(rd == gold['h030] && m0.n_fill == f + 2, "R6 third tag fill", rd, gold['h030]);
      access(0, 0, 'h022, 0, rd, lat, st);
      chk(lat == 1, "R6 recent way kept", lat, 1);
      access(0, 0, 'h012, 0, rd, lat, st);
      chk(m0.n_fill == f + 3 && rd == gold['h012], "R6 old way evicted", m0.n_fill - f, 3);

      // R7: write hit stays in cache
      wc = m0.n_write;
      access(0, 1, 'h012, 8'hA5, rd, lat, st);
      gold['h012] = 8'hA5;
      chk(m0.n_write == wc && st == 0, "R7 no memory write", m0.n_write - wc, 0);
      access(0, 0, 'h012, 0, rd, lat, st);
      chk(rd == 8'hA5 && lat == 1, "R7 read back", rd, 8'hA5);
      chk(m0.bytes['h012] == seed_byte('h012), "R7 memory unchanged", m0.bytes['h012], seed_byte('h012));

      // R8: clean victim then dirty victim
      access(0, 0, 'h040, 0, rd, lat, st);
      chk(m0.n_write == wc, "R8 clean victim no write", m0.n_write - wc, 0);
      f = m0.n_fill;
      access(0, 0, 'h050, 0, rd, lat, st);
      chk(m0.n_write == wc + 1 && m0.last_wr == 'h004, "R8 dirty write-back address", m0.last_wr, 'h004);
      chk(m0.bytes['h012] == 8'hA5, "R8 written-back byte", m0.bytes['h012], 8'hA5);
      chk(m0.n_fill == f + 1 && rd == gold['h050], "R8 fill after write-back", rd, gold['h050]);

      // R9: write miss allocates
      f = m0.n_fill; wc = m0.n_write;
      access(0, 1, 'h064, 8'h3C, rd, lat, st);
      gold['h064] = 8'h3C;
      chk(m0.n_fill == f + 1 && m0.n_write == wc, "R9 allocate fill", m0.n_fill - f, 1);
      access(0, 0, 'h064, 0, rd, lat, st);
      chk(rd == 8'h3C && lat == 1, "R9 merged byte hit", rd, 8'h3C);
      chk(m0.bytes['h064] == seed_byte('h064), "R9 memory unchanged", m0.bytes['h064], seed_byte('h064));

      // R10 / R11: write-through instance
      access(1, 0, 'h010, 0, rd, lat, st);
      f = m1.n_fill; wc = m1.n_write;
      access(1, 1, 'h011, 8'h77, rd, lat, st);
      chk(m1.n_write == wc + 1 && m1.bytes['h011] == 8'h77, "R10 write-through byte", m1.bytes['h011], 8'h77);
      chk(m1.bytes['h010] == seed_byte('h010) && m1.bytes['h012] == seed_byte('h012), "R10 single lane",
          m1.bytes['h012], seed_byte('h012));
      chk(st == 1, "R12 stall on write-through", st, 1);
      access(1, 0, 'h011, 0, rd, lat, st);
      chk(rd == 8'h77 && lat == 1 && m1.n_fill == f, "R10 cache updated", rd, 8'h77);
      access(1, 1, 'h024, 8'h99, rd, lat, st);
      chk(m1.n_write == wc + 2 && m1.n_fill == f, "R11 no allocate", m1.n_fill - f, 0);
      access(1, 0, 'h024, 0, rd, lat, st);
      chk(m1.n_fill == f + 1 && rd == 8'h99, "R11 later read misses", rd, 8'h99);

      // random mixed traffic on the write-back instance
      rnd = int'($urandom(32'd2024));
      for (int i = 0; i < 400; i++) begin
         int adr;
         bit wr;
         logic [7:0] dat;
         adr = int'($urandom % 128);
         wr  = ($urandom % 10) < 4;
         dat = 8'($urandom);
         access(0, wr, adr, dat, rd, lat, st);
         if (wr) gold[adr] = dat;
         else chk(rd == gold[adr], "R9 random read", rd, gold[adr]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule